// File: doc/BRIEF.md
# JTAG-to-debug-bus data register bridge

This block sits behind a JTAG TAP controller and turns three instruction codes into register accesses on a debug module bus. The TAP controller supplies the current 4-bit instruction and one-cycle capture, shift and update strobes. All of them are synchronous to `clk_i`, which is the test clock domain. The block supplies the serial output bit.

One instruction selects an 8-bit address register. A second instruction reads the addressed debug register into a 64-bit shift register, so the next scan shifts that value out. A third instruction does the same and also writes the bits shifted in back to the same address at Update-DR. As a result, a single data-register scan both returns the old value and stores the new one.

The debug side is a request/acknowledge port. A request and its address, write data and write enable stay valid until the acknowledge arrives.

Top module: `jtag_dmi_bridge`

## Requirements
- R1: After reset the latched address is 0, no request is pending and `tdo_o` is 0.
- R2: Under the address instruction (default 4'h8), Capture-DR loads the current address into an 8-bit shift register. Each Shift-DR cycle moves `tdi_i` in at the MSB and the LSB out on `tdo_o`, so bits leave LSB first. Update-DR makes the shifted value the new address, so an address scan returns the previous address.
- R3: The latched address (`dmi_addr_o`) changes only at Update-DR under the address instruction. Read scans and write-read scans leave it unchanged.
- R4: Capture-DR under the read instruction (default 4'h9) or the write-read instruction (default 4'hA) raises `dmi_req_o` with `dmi_we_o`=0 and the latched address. The request, its address and its write enable hold until `dmi_ack_i`.
- R5: The acknowledge of a read request loads `dmi_rdata_i` into the 64-bit shift register. The scan then returns that value on `tdo_o`, LSB first.
- R6: Under the write-read instruction, Update-DR raises a request with `dmi_we_o`=1, the latched address, and the 64 bits shifted in as `dmi_wdata_o`. The same scan returns the value the register held before the write.
- R7: Update-DR under the read instruction issues no request.
- R8: Under any other instruction, `tdo_o` is 0, the strobes issue no request, and the address is kept.
- R9: `dmi_req_o` falls in the cycle after an acknowledge. Each read scan makes exactly one request, and each write-read scan makes exactly two.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock domain |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 4 | Current instruction from the TAP |
| capture_dr_i | input | 1 | Capture-DR strobe |
| shift_dr_i | input | 1 | Shift-DR strobe, one bit per cycle |
| update_dr_i | input | 1 | Update-DR strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, LSB of the selected register |
| dmi_req_o | output | 1 | Debug bus request |
| dmi_we_o | output | 1 | Request is a write |
| dmi_addr_o | output | 8 | Latched debug register address |
| dmi_wdata_o | output | 64 | Write data |
| dmi_rdata_i | input | 64 | Read data, valid with acknowledge |
| dmi_ack_i | input | 1 | Request acknowledge |

## Verification
The assertions check the handshake on every cycle. They cover a request holding its address and write enable until acknowledge, the request falling after acknowledge, and the direction of the request that each instruction's capture or update starts. They also check that the address moves only on an address update and that foreign instructions start nothing.

The values themselves can only be shown by the bench's scans, which run against a memory model over a sweep of addresses. These include the old value returned by a write-read scan, the read value arriving LSB first, and the address scan returning the previous address.

// File: rtl/jdb_pkg.sv
package jdb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} dmi_st_e;
endpackage

// File: rtl/jdb_shreg.sv
module jdb_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         sin_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= {sin_i, q_o[W-1:1]};
  end
endmodule

// File: rtl/jdb_dmi_fsm.sv
module jdb_dmi_fsm
  import jdb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_start_i,
  input  logic wr_start_i,
  input  logic ack_i,
  output logic req_o,
  output logic we_o,
  output logic load_o
);
  dmi_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (rd_start_i) st_d = ST_RD;
               else if (wr_start_i) st_d = ST_WR;
      ST_RD, ST_WR: if (ack_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign req_o  = (st_q != ST_IDLE);
  assign we_o   = (st_q == ST_WR);
  assign load_o = (st_q == ST_RD) && ack_i;
endmodule

// File: rtl/jtag_dmi_bridge.sv
module jtag_dmi_bridge #(
  parameter int IR_W = 4,
  parameter int AW = 8,
  parameter int DW = 64,
  parameter logic [IR_W-1:0] IR_ADDR = 4'h8,
  parameter logic [IR_W-1:0] IR_READ = 4'h9,
  parameter logic [IR_W-1:0] IR_WRRD = 4'hA
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IR_W-1:0] ir_i,
  input  logic            capture_dr_i,
  input  logic            shift_dr_i,
  input  logic            update_dr_i,
  input  logic            tdi_i,
  output logic            tdo_o,
  output logic            dmi_req_o,
  output logic            dmi_we_o,
  output logic [AW-1:0]   dmi_addr_o,
  output logic [DW-1:0]   dmi_wdata_o,
  input  logic [DW-1:0]   dmi_rdata_i,
  input  logic            dmi_ack_i
);
  logic sel_addr, sel_rd, sel_wr, sel_data;
  logic [AW-1:0] asr_q, addr_q;
  logic [DW-1:0] dsr_q;
  logic load_data;

  assign sel_addr = (ir_i == IR_ADDR);
  assign sel_rd   = (ir_i == IR_READ);
  assign sel_wr   = (ir_i == IR_WRRD);
  assign sel_data = sel_rd | sel_wr;

  jdb_shreg #(.W(AW)) u_asr (
    .clk_i, .rst_ni,
    .load_i    (capture_dr_i & sel_addr),
    .load_val_i(addr_q),
    .shift_i   (shift_dr_i & sel_addr),
    .sin_i     (tdi_i),
    .q_o       (asr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       addr_q <= '0;
    else if (update_dr_i && sel_addr)  addr_q <= asr_q;
  end

  // shifting is held off while a debug access is outstanding
  jdb_shreg #(.W(DW)) u_dsr (
    .clk_i, .rst_ni,
    .load_i    (load_data),
    .load_val_i(dmi_rdata_i),
    .shift_i   (shift_dr_i & sel_data & ~dmi_req_o),
    .sin_i     (tdi_i),
    .q_o       (dsr_q)
  );

  jdb_dmi_fsm u_fsm (
    .clk_i, .rst_ni,
    .rd_start_i(capture_dr_i & sel_data),
    .wr_start_i(update_dr_i & sel_wr),
    .ack_i     (dmi_ack_i),
    .req_o     (dmi_req_o),
    .we_o      (dmi_we_o),
    .load_o    (load_data)
  );

  assign dmi_addr_o  = addr_q;
  assign dmi_wdata_o = dsr_q;
  assign tdo_o = sel_addr ? asr_q[0] : (sel_data ? dsr_q[0] : 1'b0);
endmodule

// File: rtl/jdb_checker.sv
module jdb_checker #(
  parameter int IR_W = 4,
  parameter int AW = 8,
  parameter logic [IR_W-1:0] IR_ADDR = 4'h8,
  parameter logic [IR_W-1:0] IR_READ = 4'h9,
  parameter logic [IR_W-1:0] IR_WRRD = 4'hA
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [IR_W-1:0] ir_i,
  input logic            capture_dr_i,
  input logic            update_dr_i,
  input logic            tdo_o,
  input logic            dmi_req_o,
  input logic            dmi_we_o,
  input logic [AW-1:0]   dmi_addr_o,
  input logic            dmi_ack_i
);
  logic known;
  assign known = (ir_i == IR_ADDR) || (ir_i == IR_READ) || (ir_i == IR_WRRD);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmi_req_o && !dmi_ack_i |=> dmi_req_o && $stable(dmi_we_o) && $stable(dmi_addr_o)); // R4
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmi_req_o && dmi_ack_i |=> !dmi_req_o); // R9
  AST_RD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_dr_i && (ir_i == IR_READ || ir_i == IR_WRRD) && !dmi_req_o |=> dmi_req_o && !dmi_we_o); // R4
  AST_WR_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_dr_i && ir_i == IR_WRRD && !dmi_req_o |=> dmi_req_o && dmi_we_o); // R6
  AST_RD_UPDATE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_dr_i && ir_i == IR_READ && !dmi_req_o |=> !dmi_req_o); // R7
  AST_FOREIGN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_dr_i || update_dr_i) && !known && !dmi_req_o |=> !dmi_req_o); // R8
  AST_FOREIGN_TDO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> !tdo_o); // R8
  AST_ADDR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(update_dr_i && ir_i == IR_ADDR) |=> $stable(dmi_addr_o)); // R3
endmodule

bind jtag_dmi_bridge jdb_checker #(
  .IR_W(IR_W), .AW(AW), .IR_ADDR(IR_ADDR), .IR_READ(IR_READ), .IR_WRRD(IR_WRRD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ir_i(ir_i), .capture_dr_i(capture_dr_i),
  .update_dr_i(update_dr_i), .tdo_o(tdo_o), .dmi_req_o(dmi_req_o),
  .dmi_we_o(dmi_we_o), .dmi_addr_o(dmi_addr_o), .dmi_ack_i(dmi_ack_i)
);

// File: tb/sim_jtag_dmi_bridge.sv
module sim_jtag_dmi_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;
  localparam logic [3:0] IR_A = 4'h8, IR_R = 4'h9, IR_W = 4'hA, IR_X = 4'hF;

  logic clk = 0, rst_n = 0;
  logic [3:0] ir = '0;
  logic cap = 0, sh = 0, upd = 0, tdi = 0, ack = 0;
  logic [63:0] rdata = '0;
  logic tdo, req, we;
  logic [7:0] addr;
  logic [63:0] wdata;

  int n_tests = 0, n_fail = 0, n_req = 0;
  logic last_we;
  logic [7:0] last_addr;
  logic [63:0] mem [256];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_dmi_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .capture_dr_i(cap), .shift_dr_i(sh),
    .update_dr_i(upd), .tdi_i(tdi), .tdo_o(tdo), .dmi_req_o(req), .dmi_we_o(we),
    .dmi_addr_o(addr), .dmi_wdata_o(wdata), .dmi_rdata_i(rdata), .dmi_ack_i(ack)
  );

  function automatic logic [63:0] pat(int a);
    return 64'h9e37_79b9_7f4a_7c15 * 64'(a + 1) ^ 64'h0000_0000_dead_beef;
  endfunction

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // debug bus responder with fixed latency
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (req && !ack) begin
        if (cnt == LAT) begin
          ack = 1; cnt = 0; n_req++;
          last_we = we; last_addr = addr;
          rdata = mem[addr];
          if (we) mem[addr] = wdata;
        end else cnt++;
      end else ack = 0;
    end
  end

  task automatic scan(logic [3:0] code, int len, logic [63:0] din, output logic [63:0] dout);
    ir = code; cap = 1;
    @(negedge clk); cap = 0;
    while (req) @(negedge clk);
    dout = '0;
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo;
      sh = 1; tdi = din[i];
      @(negedge clk);
    end
    sh = 0; upd = 1;
    @(negedge clk); upd = 0;
    while (req) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [7:0] cur;
    int r0;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    chk("R1 tdo", 64'(tdo), 0);
    chk("R1 req", 64'(req), 0);
    chk("R1 addr", 64'(addr), 0);
    rst_n = 1;
    @(negedge clk);
    cur = 8'h00;
    for (int a = 1; a < 256; a += 17) begin
      scan(IR_A, 8, 64'(a), d);
      chk("R2 old address out", d, 64'(cur));
      cur = 8'(a);
      chk("R2 new address", 64'(addr), 64'(cur));
      r0 = n_req;
      scan(IR_R, 64, 64'hffff_0000_ffff_0000, d);
      chk("R5 read data", d, mem[cur]);
      chk("R9 one request per read", 64'(n_req - r0), 1);
      chk("R4 read addr/we", {55'd0, last_we, last_addr}, {55'd0, 1'b0, cur});
      chk("R3 addr after read", 64'(addr), 64'(cur));
      begin
        logic [63:0] old, nv;
        old = mem[cur]; nv = ~pat(a) ^ 64'(a << 8);
        r0 = n_req;
        scan(IR_W, 64, nv, d);
        chk("R6 old value returned", d, old);
        chk("R9 two requests per write-read", 64'(n_req - r0), 2);
        chk("R6 write addr/we", {55'd0, last_we, last_addr}, {55'd0, 1'b1, cur});
        chk("R6 stored", mem[cur], nv);
        scan(IR_R, 64, '0, d);
        chk("R6 readback", d, nv);
      end
      r0 = n_req;
      scan(IR_X, 8, 64'hff, d);
      chk("R8 tdo zero", d, 0);
      chk("R8 no request", 64'(n_req - r0), 0);
      chk("R7 R3 addr kept", 64'(addr), 64'(cur));
    end
    scan(IR_A, 8, 64'h00, d);
    chk("R2 final old address", d, 64'(cur));
    chk("R2 address cleared", 64'(addr), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule